// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block is the modem register pair of an asynchronous serial controller. A control register drives four active-low handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs) and selects a loopback mode. A status register reports the current levels of four active-low modem inputs (carrier-detect, ring, data-set-ready, clear-to-send). It also keeps a sticky change flag for each input, which a read of the status register clears.

The CPU reaches both registers over a simple bus: a 3-bit address, single-cycle read and write strobes, and 8-bit data. Read data is registered. A separate pin-mode mask decides whether carrier-detect, ring and data-set-ready are reported at all. Clear-to-send is always reported. Each modem input crosses a two-flop synchroniser before its level is reported or its edges are detected.

The loopback mode is held in a two-state machine with the states MODE_NORMAL and MODE_LOOP. A write to the control register with bit 4 set moves MODE_NORMAL to MODE_LOOP. A write with bit 4 clear moves MODE_LOOP back to MODE_NORMAL. Every other cycle holds the state. In MODE_LOOP, all four handshake outputs sit at their inactive high level and the status inputs are fed from the control bits instead of from the pins.

Top module: `mdm_regs`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 with all pins idle high, every handshake output is high, and loop_on is 0.
- R2: The control register is at address 4 (binary 100). It takes wr_data[4:0] on a write and reads back with bits 7 to 5 as zero. Read data appears on rd_data at the clock edge that samples rd_en and holds until the next read.
- R3: Control bit 0 drives dtr_n, bit 1 drives rts_n, bit 2 drives out1_n and bit 3 drives out2_n. A bit at 1 drives its pin low and a bit at 0 drives it high, from the edge that takes the write.
- R4: The status register is at address 6 (binary 110). Bits 7, 6, 5 and 4 read 1 while carrier-detect, ring, data-set-ready and clear-to-send, in that order, are low. Each is visible within three clocks of the pin change.
- R5: Status bits 3, 2, 1 and 0 are change flags for carrier-detect, ring, data-set-ready and clear-to-send. A flag sets when its synchronised input changes and stays set until the status register is read.
- R6: The ring change flag (bit 2) sets only when the ring input goes from high to low. A low-to-high change leaves it clear.
- R7: A read of the status register returns the flags as they were, then clears them. A change detected in the same cycle as the read sets its flag after the read, so the change is not lost.
- R8: Pin-mode mask bit 2 enables carrier-detect, bit 1 enables ring and bit 0 enables data-set-ready. While an input is disabled, its status bit reads 0 and its change flag does not set. Clear-to-send is always reported.
- R9: Control bit 4 at 1 selects loopback and sets loop_on. In loopback all four handshake outputs are high, and the external modem pins are ignored. The status inputs then come from the control bits: bit 1 (request-to-send) feeds clear-to-send, bit 0 feeds data-set-ready, bit 2 feeds ring and bit 3 feeds carrier-detect, each read as active when its bit is 1.
- R10: Reads of any address other than 4 or 6 return 0x00. Writes to any address other than 4, including the status address, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_en | input | 3 | Report enables: bit 2 carrier-detect, bit 1 ring, bit 0 data-set-ready |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| loop_on | output | 1 | High while loopback mode is selected |

## Verification
The status path is tested with several input patterns, and each one separates a different fault.

- A single clear-to-send pulse with every mask bit off separates the always-reported input from the maskable ones.
- Carrier-detect and data-set-ready falling together, followed by a ring fall and then a ring rise, tell a symmetric change flag apart from the falling-edge-only ring flag.
- A pin change timed to reach edge detection in the same cycle as a status read shows whether the flag is lost or kept.
- Loopback is entered and left with different control patterns. This shows that external pins are ignored, that each control bit reaches the right status input, and that leaving loopback raises change flags for the inputs that move.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    // Register map
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd6;

    // Control register fields
    localparam int unsigned OUT_BITS  = 4;
    localparam int unsigned LOOP_BIT  = OUT_BITS;
    localparam int unsigned CTRL_W    = OUT_BITS + 1;
    localparam int unsigned C_DTR     = 0;
    localparam int unsigned C_RTS     = 1;
    localparam int unsigned C_OUT1    = 2;
    localparam int unsigned C_OUT2    = 3;

    // Modem line indices; status bit = index + LINES for the level, index for the flag
    localparam int unsigned LINES     = 4;
    localparam int unsigned L_CTS     = 0;
    localparam int unsigned L_DSR     = 1;
    localparam int unsigned L_RI      = 2;
    localparam int unsigned L_DCD     = 3;
    localparam int unsigned MASK_W    = LINES - 1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } mode_e;

    typedef enum logic {
        EDGE_ANY    = 1'b0,
        EDGE_ASSERT = 1'b1
    } edge_e;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Pins idle high, so every stage resets to all ones.
    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
#(
    parameter edge_e KIND = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,    // synchronised line, 1 = active
    input  logic en,     // reporting enable
    input  logic clr,    // status read in this cycle
    output logic hit,    // qualifying change seen this cycle
    output logic flag    // sticky change flag
);
    logic prev_q;

    generate
        if (KIND == EDGE_ASSERT) begin : g_assert_only
            assign hit = en & act & ~prev_q;
        end else begin : g_any
            assign hit = en & (act ^ prev_q);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= act;
            flag   <= (flag & ~clr) | hit;
        end
    end
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [CTRL_W-1:0]   wr_val,
    output logic [OUT_BITS-1:0] ctl_bits,
    output logic [DATA_W-1:0]   ctl_read,
    output logic [OUT_BITS-1:0] pins_n,
    output logic                loop_on
);
    mode_e state_q, state_d;
    logic [OUT_BITS-1:0] bits_q;

    // State register and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_NORMAL;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_stb) bits_q <= wr_val[OUT_BITS-1:0];
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (wr_stb &&  wr_val[LOOP_BIT]) state_d = MODE_LOOP;
            MODE_LOOP:   if (wr_stb && !wr_val[LOOP_BIT]) state_d = MODE_NORMAL;
            default:     state_d = MODE_NORMAL;
        endcase
    end

    // Outputs
    always_comb begin
        pins_n  = '1;
        loop_on = 1'b0;
        unique case (state_q)
            MODE_NORMAL: begin
                pins_n  = ~bits_q;
                loop_on = 1'b0;
            end
            MODE_LOOP: begin
                pins_n  = '1;
                loop_on = 1'b1;
            end
            default: begin
                pins_n  = '1;
                loop_on = 1'b0;
            end
        endcase
    end

    assign ctl_bits = bits_q;
    assign ctl_read = {{(DATA_W-CTRL_W){1'b0}}, loop_on, bits_q};
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [MASK_W-1:0] pin_en,
    input  logic              dcd_n,
    input  logic              ri_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              loop_on
);
    logic                ctl_wr, stat_rd;
    logic [OUT_BITS-1:0] ctl_bits, pins_n;
    logic [DATA_W-1:0]   ctl_read, stat_word;
    logic [LINES-1:0]    raw_n, sync_n, act_ext, act_loop, act_sel, en_full;
    logic [LINES-1:0]    dhit, dflag;

    assign ctl_wr  = wr_en && (addr == CTRL_ADDR);
    assign stat_rd = rd_en && (addr == STAT_ADDR);

    mdm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (ctl_wr),
        .wr_val   (wr_data[CTRL_W-1:0]),
        .ctl_bits (ctl_bits),
        .ctl_read (ctl_read),
        .pins_n   (pins_n),
        .loop_on  (loop_on)
    );

    assign dtr_n  = pins_n[C_DTR];
    assign rts_n  = pins_n[C_RTS];
    assign out1_n = pins_n[C_OUT1];
    assign out2_n = pins_n[C_OUT2];

    // Input lines in status order: dcd, ri, dsr, cts
    assign raw_n = {dcd_n, ri_n, dsr_n, cts_n};

    mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (sync_n)
    );

    assign act_ext  = ~sync_n;
    assign act_loop = {ctl_bits[C_OUT2], ctl_bits[C_OUT1], ctl_bits[C_DTR], ctl_bits[C_RTS]};
    assign act_sel  = loop_on ? act_loop : act_ext;
    assign en_full  = {pin_en, 1'b1};

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            localparam edge_e KIND = (i == L_RI) ? EDGE_ASSERT : EDGE_ANY;
            mdm_delta #(.KIND(KIND)) u_delta (
                .clk   (clk),
                .rst_n (rst_n),
                .act   (act_sel[i]),
                .en    (en_full[i]),
                .clr   (stat_rd),
                .hit   (dhit[i]),
                .flag  (dflag[i])
            );
        end
    endgenerate

    assign stat_word = {act_sel & en_full, dflag};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (addr)
                CTRL_ADDR: rd_data <= ctl_read;
                STAT_ADDR: rd_data <= stat_word;
                default:   rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mdm_regs_chk.sv
module mdm_regs_chk
    import mdm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [MASK_W-1:0] pin_en,
    input logic              dtr_n,
    input logic              rts_n,
    input logic              out1_n,
    input logic              out2_n,
    input logic              loop_on,
    input logic [LINES-1:0]  dhit,
    input logic [LINES-1:0]  dflag
);
    logic ctl_wr, stat_rd, other_rd;
    assign ctl_wr   = wr_en && (addr == CTRL_ADDR);
    assign stat_rd  = rd_en && (addr == STAT_ADDR);
    assign other_rd = rd_en && (addr != CTRL_ADDR) && (addr != STAT_ADDR);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == CTRL_ADDR) |=> rd_data[DATA_W-1:CTRL_W] == '0);

    a_r3_pin_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !wr_data[LOOP_BIT] |=>
            (dtr_n  == !$past(wr_data[C_DTR]))  && (rts_n  == !$past(wr_data[C_RTS])) &&
            (out1_n == !$past(wr_data[C_OUT1])) && (out2_n == !$past(wr_data[C_OUT2])));

    a_r5_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((dflag & $past(dflag)) == $past(dflag)));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> dflag == $past(dhit));

    a_r8_masked_level: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!$past(pin_en[2]) -> !rd_data[7]) &&
                    (!$past(pin_en[1]) -> !rd_data[6]) &&
                    (!$past(pin_en[0]) -> !rd_data[5]));

    a_r9_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && wr_data[LOOP_BIT] |=> loop_on && dtr_n && rts_n && out1_n && out2_n);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |=> rd_data == '0);
endmodule

bind mdm_regs mdm_regs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_en  (pin_en),
    .dtr_n   (dtr_n),
    .rts_n   (rts_n),
    .out1_n  (out1_n),
    .out2_n  (out2_n),
    .loop_on (loop_on),
    .dhit    (dhit),
    .dflag   (dflag)
);

// File: tb/test_mdm_regs.sv
`timescale 1ns/1ps
module test_mdm_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] pin_en = '0;
    logic       dcd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic       dtr_n, rts_n, out1_n, out2_n, loop_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdm_regs i_mdm_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_en(pin_en),
        .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .loop_on(loop_on)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] pins();
        return {4'b0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pins", pins(), 8'h0F);
        check("R1 loop_on", {7'b0, loop_on}, 8'h00);
        rd(3'd4, v); check("R1 ctrl", v, 8'h00);
        rd(3'd6, v); check("R1 status", v, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(3'd4, 8'hEF);
        rd(3'd4, v); check("R2 readback", v, 8'h0F);
        check("R3 all low", pins(), 8'h00);
        wr(3'd4, 8'h05);
        check("R3 dtr/out1 low", pins(), 8'h0A);
        rd(3'd4, v); check("R2 readback 05", v, 8'h05);
        wr(3'd4, 8'h00);
        check("R3 all high", pins(), 8'h0F);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        rd(3'd0, v); check("R10 read addr0", v, 8'h00);
        wr(3'd4, 8'h02);
        rd(3'd5, v); check("R10 read addr5", v, 8'h00);
        wr(3'd6, 8'hFF);
        wr(3'd1, 8'h0F);
        rd(3'd6, v); check("R10 status write ignored", v, 8'h00);
        rd(3'd4, v); check("R10 ctrl untouched", v, 8'h02);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_cts_masked();
        logic [7:0] v;
        pin_en = 3'b000;
        @(negedge clk) cts_n = 1'b0;
        settle();
        rd(3'd6, v); check("R4 R5 cts low", v, 8'h11);
        rd(3'd6, v); check("R7 flag cleared", v, 8'h10);
        @(negedge clk) begin dcd_n = 1'b0; dsr_n = 1'b0; ri_n = 1'b0; end
        settle();
        rd(3'd6, v); check("R8 masked inputs", v, 8'h10);
        @(negedge clk) begin dcd_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; cts_n = 1'b1; end
        settle();
        rd(3'd6, v); check("R5 cts rise", v, 8'h01);
        rd(3'd6, v); check("R7 cleared", v, 8'h00);
    endtask

    task automatic t_enabled();
        logic [7:0] v;
        pin_en = 3'b111;
        @(negedge clk) begin dcd_n = 1'b0; dsr_n = 1'b0; end
        settle();
        rd(3'd6, v); check("R4 R5 dcd dsr", v, 8'hAA);
        rd(3'd6, v); check("R7 levels remain", v, 8'hA0);
        @(negedge clk) ri_n = 1'b0;
        settle();
        rd(3'd6, v); check("R6 ring fall", v, 8'hE4);
        @(negedge clk) ri_n = 1'b1;
        settle();
        rd(3'd6, v); check("R6 ring rise no flag", v, 8'hA0);
        @(negedge clk) begin dcd_n = 1'b1; dsr_n = 1'b1; end
        settle();
        rd(3'd6, v); check("R5 dcd dsr rise", v, 8'h0A);
        rd(3'd6, v); check("R7 cleared", v, 8'h00);
    endtask

    task automatic t_race();
        @(negedge clk) cts_n = 1'b0;
        @(posedge clk);           // first sync stage
        @(posedge clk);           // second sync stage, change reaches detector
        @(negedge clk);
        addr = 3'd6; rd_en = 1'b1; // read in the detection cycle
        @(negedge clk);
        rd_en = 1'b0;
        check("R7 race old flags", rd_data, 8'h10);
        begin
            logic [7:0] v;
            rd(3'd6, v); check("R7 race change kept", v, 8'h11);
            rd(3'd6, v); check("R7 race cleared", v, 8'h10);
            @(negedge clk) cts_n = 1'b1;
            settle();
            rd(3'd6, v); check("R5 cts back", v, 8'h01);
            rd(3'd6, v);
        end
    endtask

    task automatic t_loop();
        logic [7:0] v;
        pin_en = 3'b111;
        wr(3'd4, 8'h13);
        check("R9 outputs idle", pins(), 8'h0F);
        check("R9 loop_on", {7'b0, loop_on}, 8'h01);
        settle();
        rd(3'd6, v); check("R9 rts->cts dtr->dsr", v, 8'h33);
        @(negedge clk) dcd_n = 1'b0;
        settle();
        rd(3'd6, v); check("R9 external ignored", v, 8'h30);
        @(negedge clk) dcd_n = 1'b1;
        wr(3'd4, 8'h17);
        settle();
        rd(3'd6, v); check("R9 out1->ring", v, 8'h74);
        wr(3'd4, 8'h1B);
        settle();
        rd(3'd6, v); check("R9 out2->dcd", v, 8'hB8);
        wr(3'd4, 8'h00);
        check("R9 loop off", {7'b0, loop_on}, 8'h00);
        settle();
        rd(3'd6, v); check("R9 leave loop flags", v, 8'h0B);
        wr(3'd4, 8'h02);
        check("R3 normal after loop", pins(), 8'h0D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_unmapped();
        t_cts_masked();
        t_enabled();
        t_race();
        t_loop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule